// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Formatter

This block turns a stream of bytes into serial update frames for a four-channel, 8-bit DAC. A request is either a single update, made of a value byte followed by a channel byte, or a list, made of a count byte followed by that many value/channel byte pairs. The `in_list` input marks which kind of request is starting. It is only looked at on the first byte of a request.

For each update the block builds a 16-bit frame and shifts it out MSB first on `dac_din`, clocked by `dac_sclk`. A chip-select style strobe, `dac_sync_n`, is held low across the whole frame. Between two frames the strobe stays high for at least one full serial clock period. `done` pulses for one cycle when a whole request has been handled. A list with a count of zero completes at once and produces no serial activity.

Top module: `qdac_writer`

## Requirements
- R1: After reset, `dac_sync_n`=1, `dac_sclk`=1, `dac_din`=0, `done`=0 and `in_ready`=1.
- R2: Frame bits 15:14 hold bits 1:0 of the channel byte. Bits 7:2 of the channel byte have no effect on the frame.
- R3: Frame bit 12 (the update-outputs flag) is 1, and frame bit 13 is 0.
- R4: Frame bits 11:8 hold value bits 7:4, frame bits 7:4 hold value bits 3:0, and frame bits 3:0 are 0.
- R5: The 16 frame bits are sent MSB first. `dac_sclk` idles high, `dac_din` is stable at every falling edge of `dac_sclk`, and each frame has exactly 16 falling edges.
- R6: `dac_sync_n` falls once before the first bit of a frame, while `dac_sclk` is high, and rises once after the 16th bit.
- R7: Between consecutive frames, `dac_sync_n` stays high for at least 2*HALF_DIV clock cycles.
- R8: With `in_list`=0 on the first byte, that byte is the value and the next accepted byte is the channel. Exactly one frame is produced, then `done` pulses.
- R9: With `in_list`=1 on the first byte, that byte is a count N. The next N value/channel pairs each produce one frame, in the order received, and `done` pulses once, after the last frame.
- R10: A list count of 0 makes `done` pulse with no `dac_sync_n` activity.
- R11: `in_ready` is 0 while a frame is being shifted out (`dac_sync_n`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Request byte (count, value or channel) |
| in_list | input | 1 | On the first byte of a request: 1 means list, 0 means single |
| dac_sclk | output | 1 | Serial clock to the DAC, idles high |
| dac_din | output | 1 | Serial data to the DAC, MSB first |
| dac_sync_n | output | 1 | Active-low frame strobe |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The bench sends single updates and lists through the byte interface and decodes every frame off the serial pins. Values 00, FF, A5, 3C, 81 and 0F check that the nibble split places each bit in its own frame position. A channel byte with high garbage bits shows that only its two low bits are used. Lists of length 4 and 1 separate list iteration and order from the single path, and a zero count shows that completion needs no serial traffic. The bench also checks the strobe gap between back-to-back list frames and checks that `done` never arrives while frames of the request are still outstanding.

// File: rtl/qdac_pkg.sv
// Package: shared constants, state types and the frame packing function
// for the quad DAC writer. Assumes an 8-bit value and a 4-channel DAC.
package qdac_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;
    localparam int BIT_CW  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_VAL, SQ_CH, SQ_WAIT} seq_st_t;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_st_t;

    // Builds the 16-bit frame: channel, spare zero, update flag, value nibbles, zero pad.
    function automatic logic [FRAME_W-1:0] pack_frame(input logic [BYTE_W-1:0] val,
                                                      input logic [BYTE_W-1:0] ch);
        return {ch[1:0], 1'b0, 1'b1, val[7:4], val[3:0], 4'b0000};
    endfunction
endpackage

// File: rtl/qdac_frame_pack.sv
// Module: qdac_frame_pack
// Forms the serial frame from the registered value and channel bytes.
// Assumes its inputs are held stable while the shifter loads.
module qdac_frame_pack
    import qdac_pkg::*;
(
    input  logic [BYTE_W-1:0]  val,
    input  logic [BYTE_W-1:0]  ch,
    output logic [FRAME_W-1:0] frame
);
    // Purely combinational packing.
    always_comb frame = pack_frame(val, ch);
endmodule

// File: rtl/qdac_shifter.sv
// Module: qdac_shifter
// Shifts one frame out MSB first. SCLK idles high, and DIN changes only as
// SCLK rises. The strobe is low across the frame, and a guard time of one
// SCLK period follows before the next frame. Assumes start only when idle.
module qdac_shifter
    import qdac_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               finish,
    output logic               sclk,
    output logic               din,
    output logic               sync_n
);
    localparam int DIV_W = $clog2(2 * HALF_DIV + 1);

    sh_st_t             st_q;
    logic [DIV_W-1:0]   div_q;
    logic               phase_q;
    logic [BIT_CW-1:0]  bit_q;
    logic [FRAME_W-1:0] sh_q;
    logic               sclk_q, sync_q, fin_q;

    // Sequences the bit timing, shift register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SH_IDLE; div_q <= '0; phase_q <= 1'b0; bit_q <= '0;
            sh_q <= '0; sclk_q <= 1'b1; sync_q <= 1'b1; fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st_q)
                SH_IDLE: if (start) begin
                    sh_q <= frame; sync_q <= 1'b0; st_q <= SH_SHIFT;
                    div_q <= '0; phase_q <= 1'b0; bit_q <= '0;
                end
                SH_SHIFT: begin
                    if (div_q == DIV_W'(HALF_DIV - 1)) begin
                        div_q <= '0;
                        if (!phase_q) begin
                            phase_q <= 1'b1; sclk_q <= 1'b0;
                        end else begin
                            phase_q <= 1'b0; sclk_q <= 1'b1;
                            sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                            if (bit_q == BIT_CW'(FRAME_W - 1)) begin
                                sync_q <= 1'b1; st_q <= SH_GAP;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                SH_GAP: begin
                    if (div_q == DIV_W'(2 * HALF_DIV - 1)) begin
                        div_q <= '0; st_q <= SH_IDLE; fin_q <= 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: st_q <= SH_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != SH_IDLE);
    assign finish = fin_q;
    assign sclk   = sclk_q;
    assign din    = sh_q[FRAME_W-1];
    assign sync_n = sync_q;

    // R6
    sync_fall_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_q) |-> sclk_q);
    // R6
    sync_rise_all_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> (sh_q == '0));
    // R5
    din_stable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_q && $past(!sclk_q) && !sync_q) |-> $stable(din));
    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |=> sync_q);
endmodule

// File: rtl/qdac_sequencer.sv
// Module: qdac_sequencer
// Accepts request bytes, splits single and list requests, holds the
// current value/channel pair and starts one frame per pair. Assumes the
// shifter signals finish once per start.
module qdac_sequencer
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_list,
    input  logic              sh_busy,
    input  logic              sh_finish,
    output logic              sh_start,
    output logic [BYTE_W-1:0] val,
    output logic [BYTE_W-1:0] ch,
    output logic              done
);
    seq_st_t           st_q;
    logic [BYTE_W-1:0] cnt_q, val_q, ch_q;
    logic              start_q, done_q;
    logic              take;

    // Byte accepted this cycle.
    always_comb take = in_valid && in_ready;

    // Request parsing and pair iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE; cnt_q <= '0; val_q <= '0; ch_q <= '0;
            start_q <= 1'b0; done_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (st_q)
                SQ_IDLE: if (take) begin
                    if (in_list) begin
                        if (in_data == '0) done_q <= 1'b1;
                        else begin cnt_q <= in_data; st_q <= SQ_VAL; end
                    end else begin
                        cnt_q <= BYTE_W'(1); val_q <= in_data; st_q <= SQ_CH;
                    end
                end
                SQ_VAL: if (take) begin val_q <= in_data; st_q <= SQ_CH; end
                SQ_CH:  if (take) begin ch_q <= in_data; start_q <= 1'b1; st_q <= SQ_WAIT; end
                SQ_WAIT: if (sh_finish) begin
                    if (cnt_q == BYTE_W'(1)) begin done_q <= 1'b1; st_q <= SQ_IDLE; end
                    else begin cnt_q <= cnt_q - 1'b1; st_q <= SQ_VAL; end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign in_ready = (st_q != SQ_WAIT);
    assign sh_start = start_q;
    assign val      = val_q;
    assign ch       = ch_q;
    assign done     = done_q;

    // R9
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !sh_busy);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !sh_busy);
    // R11
    no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !in_ready);
endmodule

// File: rtl/qdac_writer.sv
// Module: qdac_writer (top)
// Quad-channel serial DAC write formatter: byte requests in, 16-bit
// frames out on SCLK/DIN with an active-low strobe. HALF_DIV sets the
// SCLK half period in clock cycles (at least 1).
module qdac_writer
    import qdac_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_list,
    output logic       dac_sclk,
    output logic       dac_din,
    output logic       dac_sync_n,
    output logic       done
);
    logic               sh_busy, sh_finish, sh_start;
    logic [BYTE_W-1:0]  cur_val, cur_ch;
    logic [FRAME_W-1:0] frame;

    qdac_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_list(in_list), .sh_busy(sh_busy),
        .sh_finish(sh_finish), .sh_start(sh_start), .val(cur_val),
        .ch(cur_ch), .done(done)
    );

    qdac_frame_pack u_pack (.val(cur_val), .ch(cur_ch), .frame(frame));

    qdac_shifter #(.HALF_DIV(HALF_DIV)) u_sh (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .frame(frame),
        .busy(sh_busy), .finish(sh_finish), .sclk(dac_sclk),
        .din(dac_din), .sync_n(dac_sync_n)
    );

    // R11
    ready_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sync_n |-> !in_ready);
endmodule

// File: tb/qdac_writer_tb_top.sv
module qdac_writer_tb_top;
    localparam int HALF = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_list = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, dac_sclk, dac_din, dac_sync_n, done;

    int total = 0, bad = 0;
    int frames_seen = 0, falls = 0, dones = 0, dones_exp = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    qdac_writer #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_list(in_list), .dac_sclk(dac_sclk),
        .dac_din(dac_din), .dac_sync_n(dac_sync_n), .done(done)
    );

    // Expected frame built from the field rules R2..R4.
    function automatic logic [15:0] expf(input logic [7:0] v, input logic [7:0] c);
        logic [15:0] f;
        f = '0;
        f[15:14] = c[1:0];
        f[12]    = 1'b1;
        f[11:8]  = v[7:4];
        f[7:4]   = v[3:0];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: decodes frames on the serial pins and compares with the queue.
    logic prev_sclk = 1'b1, prev_sync = 1'b1;
    logic [15:0] cap = '0;
    int nbits = 0, hi_cnt = 1000;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dac_sync_n) begin
                check(in_ready == 1'b0, "R11", in_ready, 0);
                if (prev_sync) begin
                    falls++;
                    check(hi_cnt >= 2 * HALF, "R7", hi_cnt, 2 * HALF);
                    check(dac_sclk == 1'b1, "R6", dac_sclk, 1);
                    nbits = 0;
                end
                if (prev_sclk && !dac_sclk) begin
                    cap = {cap[14:0], dac_din};
                    nbits++;
                end
                hi_cnt = 0;
            end else begin
                hi_cnt++;
                if (!prev_sync) begin
                    logic [15:0] e;
                    frames_seen++;
                    check(nbits == 16, "R5", nbits, 16);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", cap, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(cap[15:14] == e[15:14], "R2", cap[15:14], e[15:14]);
                        check(cap[13:12] == e[13:12], "R3", cap[13:12], e[13:12]);
                        check(cap[11:0]  == e[11:0],  "R4", cap[11:0],  e[11:0]);
                    end
                end
                check(dac_sclk == 1'b1, "R5", dac_sclk, 1);
            end
            if (done) begin
                dones++;
                check(exp_q.size() == 0, "R9", exp_q.size(), 0);
            end
            prev_sclk = dac_sclk;
            prev_sync = dac_sync_n;
        end
    end

    task automatic put(input logic [7:0] b, input logic l);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = b; in_list = l;
        @(negedge clk);
        in_valid = 1'b0; in_list = 1'b0;
    endtask

    task automatic send_single(input logic [7:0] v, input logic [7:0] c);
        exp_q.push_back(expf(v, c));
        dones_exp++;
        put(v, 1'b0);
        put(c, 1'b0);
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 2000 && dones != dones_exp; i++) @(negedge clk);
        check(dones == dones_exp, req, dones, dones_exp);
    endtask

    task automatic run;
        logic [7:0] lv[4] = '{8'h00, 8'hFF, 8'h3C, 8'h81};
        int f0, fl0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dac_sync_n == 1'b1 && dac_sclk == 1'b1, "R1", {dac_sync_n, dac_sclk}, 3);
        check(dac_din == 1'b0 && done == 1'b0 && in_ready == 1'b1, "R1",
              {dac_din, done, in_ready}, 1);
        // R8 single update
        send_single(8'hA5, 8'h02);
        wait_done("R8");
        // R2 channel byte high bits ignored
        send_single(8'h0F, 8'hFE);
        wait_done("R2");
        // R9 list of four, in order
        put(8'd4, 1'b1);
        dones_exp++;
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(expf(lv[i], 8'(i)));
            put(lv[i], 1'b0);
            put(8'(i), 1'b0);
        end
        wait_done("R9");
        // R10 zero count
        f0 = frames_seen; fl0 = falls;
        dones_exp++;
        put(8'd0, 1'b1);
        wait_done("R10");
        repeat (20) @(negedge clk);
        check(falls == fl0 && frames_seen == f0, "R10", falls - fl0, 0);
        // R9 list of one
        put(8'd1, 1'b1);
        dones_exp++;
        exp_q.push_back(expf(8'h5A, 8'h43));
        put(8'h5A, 1'b0);
        put(8'h43, 1'b0);
        wait_done("R9");
        check(frames_seen == 7, "R9", frames_seen, 7);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule